// File: doc/BRIEF.md
# PPM Routing Correlator and Packet Switch

This block takes a serial packet stream, one bit per clock, and decides which of its output ports receive each packet. A packet opens with a single marker pulse. Two binary address bits follow, then an eight-slot pulse-position field that carries the low part of the destination address, and then a fixed-length payload. Each output port owns a routing word with one bit for every possible destination address.

The two binary bits select one eight-bit slice of every port's routing word. The slot field is ANDed with that slice, and a port matches when any bit of the result is set. The block copies the packet to every matching port, so one header can reach a single port, several ports or all ports. The packet leaves on the port lines delayed by the header-processing latency, with the marker, header and payload intact.

Software loads the routing words through a simple write port. A write that arrives while a packet is being received is held back until that packet has been routed.

Top module: `route_switch`

## Requirements
- R1: While reset is held, and after release with an idle line, `tx_bit`, `route_mask` and `hdr_bad` are all zero.
- R2: The line idles at 0. The first 1 seen while idle is the marker. The next 2 bits are the binary address bits, sent high bit first. The next 8 bits are slots 0 to 7 in that order, and slot j stands for low address value j. The next PAY_BITS bits are payload, after which the block is idle again.
- R3: A write with `tbl_we` high loads `tbl_word` into the routing word of port `tbl_sel`. Bit d of that word set means destination address d is routed to that port.
- R4: The binary bits value g (11, 10, 01, 00) selects routing-word bits [8g+7:8g]. Port k matches when slot j is set and bit 8g+j of its word is set.
- R5: A packet is copied to every matching port, which covers multicast and broadcast.
- R6: Each bit of a packet appears on a matching `tx_bit[k]` exactly 11 cycles after it entered on `rx_bit`. `route_mask` shows the matching ports from the cycle the marker leaves until the cycle after the last payload bit leaves, and is zero otherwise.
- R7: A well-formed header whose address is set in no port's word reaches no port.
- R8: A slot field with zero set slots, or with more than one, is malformed. Such a packet reaches no port, and `hdr_bad` is high over the same window in which `route_mask` would have been valid.
- R9: A table write accepted during a packet, from its marker cycle on, does not change that packet's routing and applies to the next packet.
- R10: A write whose `tbl_sel` is not below PORTS changes no routing word.
- R11: A marker that arrives in the cycle right after a payload ends is recognised, and both packets are routed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_bit | input | 1 | Serial packet stream |
| tbl_we | input | 1 | Routing-word write strobe |
| tbl_sel | input | SEL_W | Port whose routing word is written |
| tbl_word | input | 2^ADDR_W | Routing word value, bit d for address d |
| tx_bit | output | PORTS | Delayed, gated packet stream for each port |
| route_mask | output | PORTS | Ports selected for the packet now leaving |
| hdr_bad | output | 1 | The packet now leaving had a malformed slot field |

## Verification
Unicast headers for addresses 5, 12, 19 and 31 land in different slices of the routing words, which shows whether the binary bits pick the right slice and whether the slot order is reversed. Address 1 goes to two ports and address 0 to all three, which separates a real per-port AND from logic that can set only one port. Empty and double slot fields show whether the malformed check overrides a genuine match. Back-to-back packets and writes made during a packet show whether the latched mask ends at the right cycle and whether the snapshot of the table is taken at the right time.

// File: rtl/route_pkg.sv
package route_pkg;

  // Receive framing state
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_HDR  = 2'd1,
    RX_PAY  = 2'd2
  } rx_state_e;

endpackage

// File: rtl/route_rst_sync.sv
module route_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/route_hdr_rx.sv
module route_hdr_rx
  import route_pkg::*;
#(
  parameter int MSB_W    = 2,
  parameter int SLOT_W   = 8,
  parameter int PAY_BITS = 424
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  output logic              in_idle,
  output logic              hdr_fire,
  output logic [MSB_W-1:0]  hdr_msb,
  output logic [SLOT_W-1:0] hdr_slots
);

  localparam int HDR_BITS = MSB_W + SLOT_W;
  localparam int CNT_MAX  = (HDR_BITS > PAY_BITS) ? HDR_BITS : PAY_BITS;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_PAY = CNT_W'(PAY_BITS - 1);

  rx_state_e             st_q, st_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [HDR_BITS-2:0]   sh_q, sh_d;
  logic [HDR_BITS-1:0]   word;

  // next state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    unique case (st_q)
      RX_IDLE: begin
        if (rx_bit) begin
          st_d  = RX_HDR;
          cnt_d = '0;
        end
      end
      RX_HDR: begin
        sh_d = {sh_q[HDR_BITS-3:0], rx_bit};
        if (cnt_q == LAST_HDR) begin
          st_d  = RX_PAY;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      RX_PAY: begin
        if (cnt_q == LAST_PAY) begin
          st_d  = RX_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        st_d  = RX_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  // The last header bit is taken straight from the line
  assign word     = {sh_q, rx_bit};
  assign hdr_fire = (st_q == RX_HDR) && (cnt_q == LAST_HDR);
  assign in_idle  = (st_q == RX_IDLE);
  assign hdr_msb  = word[HDR_BITS-1 -: MSB_W];

  // slot 0 arrives first, so it sits highest in the shifted word
  for (genvar j = 0; j < SLOT_W; j++) begin : g_slot
    assign hdr_slots[j] = word[SLOT_W-1-j];
  end

endmodule

// File: rtl/route_tbl.sv
module route_tbl #(
  parameter int PORTS  = 3,
  parameter int ADDR_W = 5,
  parameter int MSB_W  = 2,
  localparam int SLOT_W = 1 << (ADDR_W - MSB_W),
  localparam int ENT_W  = 1 << ADDR_W,
  localparam int SEL_W  = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ENT_W-1:0]  wr_word,
  input  logic              load,
  input  logic [MSB_W-1:0]  msb,
  input  logic [SLOT_W-1:0] slots,
  output logic [PORTS-1:0]  hit,
  output logic              single
);

  localparam int GROUPS = 1 << MSB_W;

  for (genvar k = 0; k < PORTS; k++) begin : g_port
    logic [ENT_W-1:0]  staged_q, staged_d;
    logic [ENT_W-1:0]  active_q, active_d;
    logic [SLOT_W-1:0] sub;
    logic              wr_hit;

    assign wr_hit = wr_en && (wr_sel == SEL_W'(k));

    always_comb begin
      staged_d = staged_q;
      if (wr_hit) staged_d = wr_word;
      active_d = active_q;
      if (load) active_d = staged_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        staged_q <= '0;
        active_q <= '0;
      end else begin
        staged_q <= staged_d;
        active_q <= active_d;
      end
    end

    // slice chosen by the binary bits
    always_comb begin
      sub = '0;
      for (int g = 0; g < GROUPS; g++) begin
        if (msb == MSB_W'(g)) sub = active_q[g*SLOT_W +: SLOT_W];
      end
    end

    assign hit[k] = |(sub & slots);
  end

  assign single = (slots != '0) && ((slots & (slots - SLOT_W'(1))) == '0);

endmodule

// File: rtl/route_gate.sv
module route_gate #(
  parameter int PORTS   = 3,
  parameter int LAT     = 11,
  parameter int PKT_LEN = 435
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  input  logic             fire,
  input  logic [PORTS-1:0] hit,
  input  logic             single,
  output logic [PORTS-1:0] tx_bit,
  output logic [PORTS-1:0] route_mask,
  output logic             hdr_bad
);

  localparam int OCNT_W = $clog2(PKT_LEN);
  localparam logic [OCNT_W-1:0] LAST_OUT = OCNT_W'(PKT_LEN - 1);

  logic [LAT-1:0]    dly_q, dly_d;
  logic [PORTS-1:0]  mask_q, mask_d;
  logic              bad_q, bad_d;
  logic              busy_q, busy_d;
  logic [OCNT_W-1:0] ocnt_q, ocnt_d;

  always_comb begin
    dly_d  = {dly_q[LAT-2:0], rx_bit};
    mask_d = mask_q;
    bad_d  = bad_q;
    busy_d = busy_q;
    ocnt_d = ocnt_q;
    if (fire) begin
      // a new header wins over the end of the previous packet
      mask_d = single ? hit : '0;
      bad_d  = ~single;
      busy_d = 1'b1;
      ocnt_d = '0;
    end else if (busy_q) begin
      if (ocnt_q == LAST_OUT) begin
        mask_d = '0;
        bad_d  = 1'b0;
        busy_d = 1'b0;
        ocnt_d = '0;
      end else begin
        ocnt_d = ocnt_q + OCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= '0;
      mask_q <= '0;
      bad_q  <= 1'b0;
      busy_q <= 1'b0;
      ocnt_q <= '0;
    end else begin
      dly_q  <= dly_d;
      mask_q <= mask_d;
      bad_q  <= bad_d;
      busy_q <= busy_d;
      ocnt_q <= ocnt_d;
    end
  end

  assign tx_bit     = mask_q & {PORTS{dly_q[LAT-1]}};
  assign route_mask = mask_q;
  assign hdr_bad    = bad_q;

endmodule

// File: rtl/route_switch.sv
module route_switch #(
  parameter int PORTS    = 3,
  parameter int ADDR_W   = 5,
  parameter int MSB_W    = 2,
  parameter int PAY_BITS = 424,
  localparam int SEL_W   = (PORTS > 1) ? $clog2(PORTS) : 1,
  localparam int ENT_W   = 1 << ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  input  logic             tbl_we,
  input  logic [SEL_W-1:0] tbl_sel,
  input  logic [ENT_W-1:0] tbl_word,
  output logic [PORTS-1:0] tx_bit,
  output logic [PORTS-1:0] route_mask,
  output logic             hdr_bad
);

  localparam int SLOT_W   = 1 << (ADDR_W - MSB_W);
  localparam int HDR_BITS = MSB_W + SLOT_W;
  localparam int LAT      = HDR_BITS + 1;
  localparam int PKT_LEN  = 1 + HDR_BITS + PAY_BITS;

  logic              rst_s_n;
  logic              in_idle;
  logic              hdr_fire;
  logic [MSB_W-1:0]  hdr_msb;
  logic [SLOT_W-1:0] hdr_slots;
  logic [PORTS-1:0]  hit;
  logic              single;

  route_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  route_hdr_rx #(
    .MSB_W    (MSB_W),
    .SLOT_W   (SLOT_W),
    .PAY_BITS (PAY_BITS)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .rx_bit    (rx_bit),
    .in_idle   (in_idle),
    .hdr_fire  (hdr_fire),
    .hdr_msb   (hdr_msb),
    .hdr_slots (hdr_slots)
  );

  route_tbl #(
    .PORTS  (PORTS),
    .ADDR_W (ADDR_W),
    .MSB_W  (MSB_W)
  ) u_tbl (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (tbl_we),
    .wr_sel  (tbl_sel),
    .wr_word (tbl_word),
    .load    (in_idle),
    .msb     (hdr_msb),
    .slots   (hdr_slots),
    .hit     (hit),
    .single  (single)
  );

  route_gate #(
    .PORTS   (PORTS),
    .LAT     (LAT),
    .PKT_LEN (PKT_LEN)
  ) u_gate (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .rx_bit     (rx_bit),
    .fire       (hdr_fire),
    .hit        (hit),
    .single     (single),
    .tx_bit     (tx_bit),
    .route_mask (route_mask),
    .hdr_bad    (hdr_bad)
  );

endmodule

// File: rtl/route_chk.sv
module route_chk #(
  parameter int PORTS = 3,
  parameter int LAT   = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_bit,
  input logic             fire,
  input logic [PORTS-1:0] tx_bit,
  input logic [PORTS-1:0] route_mask,
  input logic             hdr_bad
);

  // R8
  bad_no_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_bad |-> (route_mask == '0));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(route_mask) |-> ($past(fire) || (route_mask == '0)));

  // R2
  marker_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(rx_bit, LAT - 1));

  for (genvar k = 0; k < PORTS; k++) begin : g_port
    // R6
    data_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      route_mask[k] |-> (tx_bit[k] == $past(rx_bit, LAT)));

    // R5
    idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !route_mask[k] |-> !tx_bit[k]);
  end

endmodule

bind route_switch route_chk #(
  .PORTS (PORTS),
  .LAT   (LAT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .rx_bit     (rx_bit),
  .fire       (hdr_fire),
  .tx_bit     (tx_bit),
  .route_mask (route_mask),
  .hdr_bad    (hdr_bad)
);

// File: tb/test_route_switch.sv
module test_route_switch;

  localparam int PORTS    = 3;
  localparam int PAY_BITS = 424;
  localparam int PKT_LEN  = 1 + 10 + PAY_BITS;
  localparam int LAT      = 11;
  localparam int MAXS     = 2048;

  localparam logic [31:0] W0 = 32'h0008_0023; // addr 0,1,5,19
  localparam logic [31:0] W1 = 32'h0000_1003; // addr 0,1,12
  localparam logic [31:0] W2 = 32'h8000_0001; // addr 0,31

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_bit = 1'b0;
  logic             tbl_we = 1'b0;
  logic [1:0]       tbl_sel = '0;
  logic [31:0]      tbl_word = '0;
  logic [PORTS-1:0] tx_bit;
  logic [PORTS-1:0] route_mask;
  logic             hdr_bad;

  int n_chk = 0;
  int n_fail = 0;

  logic             s_bit  [MAXS];
  logic [PORTS-1:0] s_mask [MAXS];
  logic             s_bad  [MAXS];
  int               s_len;
  int               mw_idx;
  logic [1:0]       mw_sel;
  logic [31:0]      mw_word;

  always #2 clk = ~clk;

  route_switch i_route_switch (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_bit     (rx_bit),
    .tbl_we     (tbl_we),
    .tbl_sel    (tbl_sel),
    .tbl_word   (tbl_word),
    .tx_bit     (tx_bit),
    .route_mask (route_mask),
    .hdr_bad    (hdr_bad)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] word);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = sel; tbl_word = word;
    @(negedge clk);
    tbl_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clr_stream();
    s_len  = 0;
    mw_idx = -1;
  endtask

  task automatic add_gap(input int n);
    for (int i = 0; i < n; i++) begin
      s_bit[s_len] = 1'b0; s_mask[s_len] = '0; s_bad[s_len] = 1'b0;
      s_len++;
    end
  endtask

  task automatic add_pkt(input logic [1:0] msb, input logic [7:0] ppm,
                         input int seed, input logic [PORTS-1:0] mask,
                         input logic bad);
    for (int i = 0; i < PKT_LEN; i++) begin
      s_mask[s_len + i] = mask;
      s_bad[s_len + i]  = bad;
    end
    s_bit[s_len]     = 1'b1;
    s_bit[s_len + 1] = msb[1];
    s_bit[s_len + 2] = msb[0];
    for (int j = 0; j < 8; j++) s_bit[s_len + 3 + j] = ppm[j];
    for (int i = 0; i < PAY_BITS; i++)
      s_bit[s_len + 11 + i] = (((i * 5 + seed) % 7) < 3);
    s_len += PKT_LEN;
  endtask

  task automatic add_addr(input logic [4:0] addr, input int seed,
                          input logic [PORTS-1:0] mask);
    add_pkt(addr[4:3], 8'(1 << addr[2:0]), seed, mask, 1'b0);
  endtask

  // Drive the stream and compare each output bit 11 cycles later
  task automatic run_stream(input string req);
    int e_dat = 0, e_msk = 0, e_bad = 0;
    fork
      begin
        for (int j = 0; j < s_len; j++) begin
          @(negedge clk);
          rx_bit = s_bit[j];
        end
        @(negedge clk);
        rx_bit = 1'b0;
      end
      begin
        for (int idx = 0; idx < s_len + LAT; idx++) begin
          @(negedge clk);
          if (idx >= LAT) begin
            int j = idx - LAT;
            if (tx_bit !== (s_bit[j] ? s_mask[j] : '0)) e_dat++;
            if (route_mask !== s_mask[j]) e_msk++;
            if (hdr_bad !== s_bad[j]) e_bad++;
          end
        end
      end
      begin
        if (mw_idx >= 0) begin
          repeat (mw_idx + 1) @(negedge clk);
          tbl_we = 1'b1; tbl_sel = mw_sel; tbl_word = mw_word;
          @(negedge clk);
          tbl_we = 1'b0;
        end
      end
    join
    chk(e_dat == 0, req, "tx_bit mismatches", e_dat, 0);
    chk(e_msk == 0, req, "route_mask mismatches", e_msk, 0);
    chk(e_bad == 0, req, "hdr_bad mismatches", e_bad, 0);
    repeat (3) @(negedge clk);
    // R6 mask cleared once the stream has drained
    chk(route_mask == '0 && tx_bit == '0, "R6", "idle after stream",
        {route_mask, tx_bit}, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(tx_bit == '0 && route_mask == '0 && hdr_bad == 1'b0, "R1",
        "outputs in reset", {tx_bit, route_mask, hdr_bad}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(tx_bit == '0 && route_mask == '0 && hdr_bad == 1'b0, "R1",
        "outputs after release", {tx_bit, route_mask, hdr_bad}, 0);
  endtask

  task automatic t_load();
    wr(2'd0, W0);
    wr(2'd1, W1);
    wr(2'd2, W2);
  endtask

  // R2 R4: one port per address, each in a different slice
  task automatic t_unicast();
    clr_stream();
    add_addr(5'd5, 1, 3'b001);  add_gap(4);
    add_addr(5'd12, 2, 3'b010); add_gap(2);
    add_addr(5'd19, 3, 3'b001); add_gap(5);
    add_addr(5'd31, 4, 3'b100); add_gap(1);
    run_stream("R4");
  endtask

  // R5: address 1 to two ports, address 0 to all
  task automatic t_multicast();
    clr_stream();
    add_addr(5'd1, 5, 3'b011); add_gap(3);
    add_addr(5'd0, 6, 3'b111); add_gap(2);
    run_stream("R5");
  endtask

  // R7: address 7 is in no routing word
  task automatic t_nomatch();
    clr_stream();
    add_addr(5'd7, 7, 3'b000); add_gap(2);
    run_stream("R7");
  endtask

  // R8: empty slot field, then two slots that would both match
  task automatic t_malformed();
    clr_stream();
    add_pkt(2'b00, 8'b0000_0000, 8, 3'b000, 1'b1); add_gap(3);
    add_pkt(2'b00, 8'b0000_0011, 9, 3'b000, 1'b1); add_gap(3);
    add_addr(5'd12, 10, 3'b010); add_gap(2);
    run_stream("R8");
  endtask

  // R11: second marker right after the first payload ends
  task automatic t_back2back();
    clr_stream();
    add_addr(5'd12, 11, 3'b010);
    add_addr(5'd31, 12, 3'b100);
    add_gap(2);
    run_stream("R11");
  endtask

  // R9: write during the header applies only to the next packet
  task automatic t_midwrite();
    clr_stream();
    add_addr(5'd5, 13, 3'b001); add_gap(3);
    add_addr(5'd5, 14, 3'b011); add_gap(2);
    mw_idx  = 4;
    mw_sel  = 2'd1;
    mw_word = W1 | 32'h0000_0020;
    run_stream("R9");
    wr(2'd1, W1);
  endtask

  // R10: selector beyond the last port is ignored
  task automatic t_badsel();
    wr(2'd3, 32'hFFFF_FFFF);
    clr_stream();
    add_addr(5'd7, 15, 3'b000); add_gap(2);
    add_addr(5'd24, 16, 3'b000); add_gap(2);
    run_stream("R10");
  endtask

  // R3: idle write adds address 7 to port 2
  task automatic t_write();
    wr(2'd2, W2 | 32'h0000_0080);
    clr_stream();
    add_addr(5'd7, 17, 3'b100); add_gap(2);
    add_addr(5'd31, 18, 3'b100); add_gap(2);
    run_stream("R3");
    wr(2'd2, W2);
  endtask

  initial begin
    t_reset();
    t_load();
    t_unicast();
    t_multicast();
    t_nomatch();
    t_malformed();
    t_back2back();
    t_midwrite();
    t_badsel();
    t_write();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule